// File: doc/BRIEF.md
# DMA Request and Bus-Hold Controller

This block governs one DMA channel: it decides when an operand transfer is wanted, wins the system bus through a request/grant handshake, strobes an active-low acknowledge for each operand, and chooses when to give the bus back. Requests come either from an active-low external line, recognised only on its falling edge, or from an internal generator. The internal generator runs at full rate, with a request always pending, or throttled to one request every N clocks.

With external requests, a mode field picks the bus policy. In burst mode, operands run back to back while the line stays low. In cycle steal, the bus is returned after every operand. In cycle steal with hold, the bus is kept for a programmable number of clocks after each operand, so that a fresh request can be served without arbitrating again. A transfer counter stops the channel when it reaches zero. A start/done pair paces an external sequencer that moves the actual data.

Top module: `dma_hold_ctrl`

## Requirements
- R1: After reset, bus_req is 0, ack_n is 1, own_n is 1, xfer_start is 0 and done is 0.
- R2: With the request-source field (control bits 1:0, written at select 0) at 10 or 11, each falling edge of ext_req_n yields one operand. A level held low without a falling edge yields none.
- R3: The channel raises bus_req first, and drives own_n and ack_n low only after bus_grant is seen high. ack_n is low from the cycle xfer_start pulses until xfer_done ends the operand.
- R4: With an external source and mode field (control bits 3:2) equal to 10 or 01, the channel releases the bus (bus_req and own_n high) after every operand, so arbitrations equal operands.
- R5: With an external source and mode 11, after each operand own_n stays low with ack_n high for exactly H cycles, where H is the hold value at select 1 and 0 counts as 1. A request inside that window is served with no new rise of bus_req.
- R6: With an external source and mode 00, a falling edge starts operands that repeat back to back while ext_req_n stays low, using one arbitration. The bus is released at the end of the first operand that finishes with ext_req_n high.
- R7: With source 00, a request is always pending and the mode field is ignored. The bus is released after each operand.
- R8: With source 01, one request is generated every N cycles, where N is the value at select 2 and 0 counts as 1, so operand starts are N cycles apart when N exceeds the service time.
- R9: Writing select 3 loads the transfer count and clears done. Each xfer_done decrements the count. When it reaches zero, the bus is released, done goes to 1 and further requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 hold, 2 rate, 3 count |
| cfg_wdata | input | DW | Register write data |
| ext_req_n | input | 1 | Active-low external request |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| ack_n | output | 1 | Active-low operand acknowledge |
| own_n | output | 1 | Active-low bus ownership |
| xfer_start | output | 1 | One-cycle pulse starting an operand in the sequencer |
| xfer_done | input | 1 | Sequencer reports the operand finished |
| done | output | 1 | Transfer count exhausted |

## Verification
A wrong channel state shows at the ports within one cycle of the next grant or xfer_done. The signs are an acknowledge without ownership, a bus that stays owned after a steal, or a fresh bus_req rise during a hold window. A lost or duplicated request latch shows as an operand count that differs from the number of falling edges once the run settles. A hold timer off by one moves the end of ownership by exactly one cycle, and the bench counts those cycles directly.

// File: rtl/dmh_pkg.sv
package dmh_pkg;

    localparam logic [1:0] SRC_MAXRATE = 2'b00;
    localparam logic [1:0] SRC_LIMITED = 2'b01;

    localparam logic [1:0] XM_BURST = 2'b00;
    localparam logic [1:0] XM_HOLD  = 2'b11;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_HOLD  = 2'd1;
    localparam logic [1:0] SEL_RATE  = 2'd2;
    localparam logic [1:0] SEL_COUNT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_XFER,
        ST_HOLD
    } chan_state_e;

    typedef enum logic [1:0] {
        POL_BURST,
        POL_STEAL,
        POL_HOLD
    } release_pol_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] src;
    } chan_cfg_t;

    function automatic logic is_external(chan_cfg_t c);
        return c.src[1];
    endfunction

    function automatic release_pol_e pick_policy(chan_cfg_t c);
        if (!is_external(c))
            return POL_STEAL;
        else if (c.mode == XM_BURST)
            return POL_BURST;
        else if (c.mode == XM_HOLD)
            return POL_HOLD;
        else
            return POL_STEAL;
    endfunction

endpackage

// File: rtl/dmh_req_gen.sv
module dmh_req_gen
    import dmh_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  chan_cfg_t     cfg,
    input  logic [RW-1:0] rate,
    input  logic          ext_req_n,
    input  logic          consume,
    output logic          pending
);

    localparam logic [RW-1:0] ONE = RW'(1);

    logic          ext_q;
    logic          fall;
    logic [RW-1:0] rate_eff;
    logic [RW-1:0] lim_cnt;
    logic          tick;
    logic          new_req;
    logic          pend_q;
    logic          ext_mode;
    logic          lim_mode;

    assign ext_mode = is_external(cfg);
    assign lim_mode = (cfg.src == SRC_LIMITED);
    assign fall     = ext_q && !ext_req_n;
    assign rate_eff = (rate == '0) ? ONE : rate;
    assign tick     = lim_mode && (lim_cnt >= rate_eff - ONE);
    assign new_req  = ext_mode ? fall : tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b1;
        end else begin
            ext_q <= ext_req_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !lim_mode) begin
            lim_cnt <= '0;
        end else if (tick) begin
            lim_cnt <= '0;
        end else begin
            lim_cnt <= lim_cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !consume) || new_req;
        end
    end

    assign pending = (cfg.src == SRC_MAXRATE) ? 1'b1 : pend_q;

    AST_LEVEL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && !clear && !ext_q && !ext_req_n && !pend_q) |=> !pend_q); // R2

    AST_LIMIT_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (lim_mode && !clear) |=> (lim_cnt < rate_eff) || $changed(rate)); // R8

endmodule

// File: rtl/dmh_hold_timer.sv
module dmh_hold_timer #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [HW-1:0] period,
    output logic          last
);

    localparam logic [HW-1:0] ONE = HW'(1);

    logic [HW-1:0] t_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else if (load) begin
            t_q <= (period == '0) ? ONE : period;
        end else if (run && t_q != '0) begin
            t_q <= t_q - ONE;
        end
    end

    assign last = (t_q == ONE);

    AST_HOLD_TIMER_LIVE: assert property (@(posedge clk) disable iff (rst)
        run |-> (t_q != '0)); // R5

endmodule

// File: rtl/dmh_xfer_count.sv
module dmh_xfer_count #(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] ld_val,
    input  logic          dec,
    output logic          zero,
    output logic          last
);

    localparam logic [NW-1:0] ONE = NW'(1);

    logic [NW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= ld_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign zero = (rem_q == '0);
    assign last = (rem_q == ONE);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (rem_q != '0)); // R9

endmodule

// File: rtl/dma_hold_ctrl.sv
module dma_hold_ctrl
    import dmh_pkg::*;
#(
    parameter int DW = 16,
    parameter int HW = DW,
    parameter int RW = DW,
    parameter int NW = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          ext_req_n,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          ack_n,
    output logic          own_n,
    output logic          xfer_start,
    input  logic          xfer_done,
    output logic          done
);

    localparam int CTRL_BITS = $bits(chan_cfg_t);

    chan_cfg_t     cfg_q;
    logic [HW-1:0] hold_q;
    logic [RW-1:0] rate_q;

    chan_state_e   state_q, state_d;
    release_pol_e  policy;

    logic pending;
    logic consume;
    logic hold_load;
    logic hold_last;
    logic cnt_dec;
    logic cnt_zero;
    logic cnt_last;
    logic cnt_load;
    logic finish;
    logic start_q;
    logic done_q;

    // register port
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            hold_q <= '0;
            rate_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: cfg_q  <= chan_cfg_t'(cfg_wdata[CTRL_BITS-1:0]);
                SEL_HOLD: hold_q <= cfg_wdata[HW-1:0];
                SEL_RATE: rate_q <= cfg_wdata[RW-1:0];
                default:  ;
            endcase
        end
    end

    assign cnt_load = cfg_we && (cfg_sel == SEL_COUNT);
    assign policy   = pick_policy(cfg_q);

    dmh_req_gen #(.RW(RW)) u_req (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_we),
        .cfg       (cfg_q),
        .rate      (rate_q),
        .ext_req_n (ext_req_n),
        .consume   (consume),
        .pending   (pending)
    );

    dmh_hold_timer #(.HW(HW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (hold_load),
        .run    (state_q == ST_HOLD),
        .period (hold_q),
        .last   (hold_last)
    );

    dmh_xfer_count #(.NW(NW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (cnt_load),
        .ld_val (cfg_wdata[NW-1:0]),
        .dec    (cnt_dec),
        .zero   (cnt_zero),
        .last   (cnt_last)
    );

    // channel sequencing
    always_comb begin
        state_d   = state_q;
        consume   = 1'b0;
        hold_load = 1'b0;
        cnt_dec   = 1'b0;
        finish    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!cnt_zero && pending)
                    state_d = ST_ARB;
            end
            ST_ARB: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end else if (bus_grant) begin
                    state_d = ST_XFER;
                    consume = 1'b1;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        case (policy)
                            POL_BURST: state_d = ext_req_n ? ST_IDLE : ST_XFER;
                            POL_HOLD: begin
                                state_d   = ST_HOLD;
                                hold_load = 1'b1;
                            end
                            default:   state_d = ST_IDLE;
                        endcase
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end else if (pending) begin
                    state_d = ST_XFER;
                    consume = 1'b1;
                end else if (hold_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_d == ST_XFER) && ((state_q != ST_XFER) || xfer_done);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_load) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end
    end

    assign bus_req    = (state_q != ST_IDLE);
    assign own_n      = !((state_q == ST_XFER) || (state_q == ST_HOLD));
    assign ack_n      = (state_q != ST_XFER);
    assign xfer_start = start_q;
    assign done       = done_q;

    AST_OWN_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $fell(own_n) |-> $past(bus_grant)); // R3

    AST_START_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> !ack_n); // R3

    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && xfer_done && policy == POL_STEAL) |=> own_n); // R4

    AST_HOLD_NO_REARB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && pending && !cnt_zero) |=> (!ack_n && !$rose(bus_req))); // R5

    AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && xfer_done && policy == POL_BURST && !ext_req_n && !cnt_last)
        |=> xfer_start); // R6

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (own_n && !bus_req)); // R9

endmodule

// File: tb/dma_hold_ctrl_test.sv
`timescale 1ns/1ps
module dma_hold_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        ext_req_n = 1'b1;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        ack_n;
    logic        own_n;
    logic        xfer_start;
    logic        xfer_done = 1'b0;
    logic        done;

    always #2 clk = ~clk;

    dma_hold_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ext_req_n(ext_req_n), .bus_req(bus_req), .bus_grant(bus_grant), .ack_n(ack_n),
        .own_n(own_n), .xfer_start(xfer_start), .xfer_done(xfer_done), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int ops = 0;
    int arbs = 0;
    int holdc = 0;
    int cyc = 0;
    int st_t[4];
    bit breq_q = 1'b0;
    bit grant_block = 1'b0;
    int dcnt = 0;

    // bus arbiter, sequencer and monitor, all acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (xfer_start) begin
                if (ops < 4) st_t[ops] = cyc;
                ops++;
            end
            if (bus_req && !breq_q) arbs++;
            breq_q = bus_req;
            if (!own_n && ack_n) holdc++;
            bus_grant = bus_req && !grant_block;
            xfer_done = (dcnt == 1);
            if (dcnt > 0) dcnt--;
            if (xfer_start) dcnt = 2;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_mon();
        ops = 0; arbs = 0; holdc = 0;
    endtask

    task automatic setup(input logic [1:0] src, input logic [1:0] mode,
                         input logic [15:0] hold, input logic [15:0] rate);
        wr(2'd3, 16'd0);
        wr(2'd0, {12'd0, mode, src});
        wr(2'd1, hold);
        wr(2'd2, rate);
    endtask

    task automatic pulse_req();
        @(negedge clk); ext_req_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_req_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    typedef struct packed {
        logic [1:0]  src;
        logic [1:0]  mode;
        logic [15:0] hold;
        logic [15:0] rate;
        logic [15:0] cnt;
        int          edges;
        int          spacing;
        int          eops;
        int          earbs;
        logic        edone;
    } row_t;

    // src, mode, hold, rate, count, edges, spacing, ops, arbitrations, done
    localparam row_t ROWS [8] = '{
        '{2'b10, 2'b10, 16'd5,  16'd0,  16'd6, 4, 30, 4, 4, 1'b0},  // R4 steal
        '{2'b10, 2'b01, 16'd5,  16'd0,  16'd5, 3, 30, 3, 3, 1'b0},  // R4 mode 01
        '{2'b10, 2'b11, 16'd20, 16'd0,  16'd9, 4, 10, 4, 1, 1'b0},  // R5 held
        '{2'b10, 2'b11, 16'd5,  16'd0,  16'd9, 4, 40, 4, 4, 1'b0},  // R5 expiry
        '{2'b11, 2'b10, 16'd5,  16'd0,  16'd2, 4, 30, 2, 2, 1'b1},  // R9 stop
        '{2'b00, 2'b11, 16'd9,  16'd0,  16'd3, 0, 0,  3, 3, 1'b1},  // R7 mode ignored
        '{2'b01, 2'b00, 16'd0,  16'd12, 16'd3, 0, 0,  3, 3, 1'b1},  // R8 limited
        '{2'b00, 2'b00, 16'd0,  16'd0,  16'd1, 0, 0,  1, 1, 1'b1}   // R7 R9 single
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
        check(ack_n == 1'b1 && own_n == 1'b1, "R1 ack_n/own_n", int'({ack_n, own_n}), 3);
        check(xfer_start == 1'b0 && done == 1'b0, "R1 start/done", int'({xfer_start, done}), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(bus_req == 1'b0 && own_n == 1'b1 && done == 1'b0, "R1 after release", int'(bus_req), 0);

        foreach (ROWS[i]) begin
            setup(ROWS[i].src, ROWS[i].mode, ROWS[i].hold, ROWS[i].rate);
            clr_mon();
            wr(2'd3, ROWS[i].cnt);
            for (int e = 0; e < ROWS[i].edges; e++) begin
                repeat (ROWS[i].spacing) @(negedge clk);
                pulse_req();
            end
            repeat (150) @(negedge clk);
            check(ops == ROWS[i].eops, $sformatf("R2 row %0d operands", i), ops, ROWS[i].eops);
            check(arbs == ROWS[i].earbs, $sformatf("R4 R5 R7 row %0d arbitrations", i), arbs, ROWS[i].earbs);
            check(done == ROWS[i].edone, $sformatf("R9 row %0d done", i), int'(done), int'(ROWS[i].edone));
            check(own_n == 1'b1 && bus_req == 1'b0, $sformatf("R4 row %0d bus released", i), int'(own_n), 1);
        end

        // R2: a level held low is not a request, a later falling edge is
        setup(2'b10, 2'b10, 16'd5, 16'd0);
        @(negedge clk); ext_req_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_mon();
        wr(2'd3, 16'd5);
        repeat (50) @(negedge clk);
        check(ops == 0, "R2 steady low ignored", ops, 0);
        ext_req_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse_req();
        repeat (30) @(negedge clk);
        check(ops == 1, "R2 edge after level", ops, 1);

        // R3: nothing owned or acknowledged before the grant
        setup(2'b00, 2'b10, 16'd0, 16'd0);
        grant_block = 1'b1;
        clr_mon();
        wr(2'd3, 16'd1);
        repeat (20) @(negedge clk);
        check(bus_req == 1'b1, "R3 request raised", int'(bus_req), 1);
        check(own_n == 1'b1 && ack_n == 1'b1 && ops == 0, "R3 waits for grant", ops, 0);
        grant_block = 1'b0;
        repeat (20) @(negedge clk);
        check(ops == 1 && done == 1'b1, "R3 served after grant", ops, 1);

        // R5: hold window length
        setup(2'b10, 2'b11, 16'd8, 16'd0);
        clr_mon();
        wr(2'd3, 16'd5);
        repeat (5) @(negedge clk);
        pulse_req();
        repeat (60) @(negedge clk);
        check(holdc == 8, "R5 hold cycles", holdc, 8);
        check(ops == 1 && arbs == 1 && own_n == 1'b1, "R5 released after window", arbs, 1);

        // R5: hold value 0 counts as 1
        setup(2'b10, 2'b11, 16'd0, 16'd0);
        clr_mon();
        wr(2'd3, 16'd5);
        pulse_req();
        repeat (40) @(negedge clk);
        check(holdc == 1, "R5 zero hold as one", holdc, 1);

        // R8: operand starts spaced by the rate value
        setup(2'b01, 2'b00, 16'd0, 16'd12);
        clr_mon();
        wr(2'd3, 16'd3);
        repeat (80) @(negedge clk);
        check(st_t[1] - st_t[0] == 12, "R8 spacing first", st_t[1] - st_t[0], 12);
        check(st_t[2] - st_t[1] == 12, "R8 spacing second", st_t[2] - st_t[1], 12);

        // R6: burst runs to the count while held low
        setup(2'b10, 2'b00, 16'd0, 16'd0);
        clr_mon();
        wr(2'd3, 16'd4);
        @(negedge clk); ext_req_n = 1'b0;
        repeat (100) @(negedge clk);
        check(ops == 4 && arbs == 1, "R6 burst one arbitration", arbs, 1);
        check(done == 1'b1 && own_n == 1'b1, "R6 R9 burst ends done", int'(done), 1);
        ext_req_n = 1'b1;

        // R6: burst released when the line goes high
        setup(2'b10, 2'b00, 16'd0, 16'd0);
        clr_mon();
        wr(2'd3, 16'd20);
        @(negedge clk); ext_req_n = 1'b0;
        repeat (15) @(negedge clk);
        ext_req_n = 1'b1;
        repeat (30) @(negedge clk);
        check(ops >= 2 && ops < 20 && arbs == 1, "R6 burst partial", ops, 4);
        check(own_n == 1'b1 && bus_req == 1'b0 && done == 1'b0, "R6 burst release", int'(own_n), 1);

        // R9: edges after done are ignored
        setup(2'b10, 2'b10, 16'd0, 16'd0);
        clr_mon();
        wr(2'd3, 16'd1);
        pulse_req();
        repeat (30) @(negedge clk);
        pulse_req();
        repeat (30) @(negedge clk);
        check(ops == 1 && done == 1'b1 && own_n == 1'b1, "R9 ignored after zero", ops, 1);

        finish_run();
    end

endmodule